// File: doc/BRIEF.md
# Bus-Stalling Debug Serial Transmitter

This block is a transmit-only serial port meant to hang on a simple processor memory bus as a log output. Software sees a single write-only data register. A bus write whose byte strobes are not all zero takes the low byte of the write data and sends it as one asynchronous character: a low start bit, the data bits least significant first, and a high stop bit. The line rests high between characters. The bit period is a whole number of clock cycles, fixed when the block is built (clock frequency over baud rate).

Two ways of pacing software are offered through the `HOLD_ACK` parameter. With `HOLD_ACK = 1` the write is not acknowledged until its stop bit has finished. The processor therefore stalls at the line rate, and a print loop can store byte after byte without polling and without any chance of overrun. With `HOLD_ACK = 0` the write is acknowledged at once. The one-cycle `tx_done` pulse then serves as an end-of-character interrupt so that software can keep its own queue. In this mode a write that arrives during a character waits on the bus until the line is free. Reads are acknowledged and always return zero. They never start a character and never disturb one that is under way.

The control sequencer has five states. `ST_IDLE` waits for a write. The accept transition leads to `ST_START`. The first bit-tick leads to `ST_DATA`, which repeats on each tick until the last data bit. The final data tick leads to `ST_STOP`. The stop tick leads to `ST_ACK`, which lasts one cycle and then falls back unconditionally to `ST_IDLE`.

Top module: `dbg_uart_tx`

## Requirements
- R1: During and right after reset, `tx_out` is 1, `bus_ready` is 0 and `tx_done` is 0.
- R2: A write (`bus_valid` = 1 and `bus_wstrb` not zero) seen at a clock edge in the idle state starts a character. `tx_out` is 0 for `CLK_DIV` cycles, starting in the cycle after that edge.
- R3: Bits `bus_wdata[DATA_BITS-1:0]` follow the start bit, least significant first, each held for `CLK_DIV` cycles. Bits of `bus_wdata` above `DATA_BITS` have no effect on the line.
- R4: After the last data bit, `tx_out` is 1 for a stop period of `CLK_DIV` cycles. It then stays 1 until the next accepted write.
- R5: With `HOLD_ACK = 1`, `bus_ready` stays 0 for the whole character. It is 1 for exactly one cycle: the cycle that begins `(DATA_BITS+2)*CLK_DIV` edges after the accepting edge.
- R6: `tx_done` is 1 for exactly one cycle per character, in that same cycle after the stop bit, in both modes.
- R7: With `HOLD_ACK = 0`, an accepted write is acknowledged by a one-cycle `bus_ready` in the cycle after the accepting edge. A write that arrives during a character sees `bus_ready` = 0 until the `ST_ACK` cycle has passed. It is accepted at the next edge, and that character follows with a two-cycle high gap after the stop bit.
- R8: A read (`bus_valid` = 1, `bus_wstrb` = 0) gets a one-cycle `bus_ready` in the cycle after the request edge, with `bus_rdata` = 0. It starts no character and leaves any character in progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus request, held until `bus_ready` |
| bus_wstrb | input | BUS_W/8 | Byte write strobes; all zero marks a read |
| bus_wdata | input | BUS_W | Write data; low `DATA_BITS` bits are sent |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | BUS_W | Read data, always zero |
| tx_out | output | 1 | Serial line, idles high |
| tx_done | output | 1 | One-cycle end-of-character pulse |

## Verification
The bench builds two copies with `CLK_DIV = 4` and `DATA_BITS = 8`: `dut_i` with `HOLD_ACK = 1` and a posted copy with `HOLD_ACK = 0`. A bit period of four cycles keeps a character at forty cycles. That gives a true mid-bit sample point and makes it cheap to walk many characters and to place a read and a queued write inside a single frame. The two copies cover both pacing styles, including the stalled write that follows a character back to back and the exact acknowledge cycle in each mode.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_ACK
    } tx_state_e;

endpackage

// File: rtl/dbg_uart_baud.sv
// Bit-period timer: counts while a character is on the line, pulses at the
// last cycle of each bit period, held at zero otherwise.
module dbg_uart_baud #(
    parameter int CLK_DIV = 868
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/dbg_uart_shreg.sv
// Character shift register: parallel load, shifts toward bit 0, fills with ones.
module dbg_uart_shreg #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic [DATA_BITS-1:0] din,
    output logic                 lsb
);
    logic [DATA_BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= din;
        end else if (shift) begin
            sh_q <= {1'b1, sh_q[DATA_BITS-1:1]};
        end
    end

    assign lsb = sh_q[0];

endmodule

// File: rtl/dbg_uart_ctrl.sv
// Character sequencer: start, data bits, stop, one acknowledge cycle.
module dbg_uart_ctrl
    import dbg_uart_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_req,
    input  logic      tick,
    input  logic      data_lsb,
    output tx_state_e st,
    output logic      accept,
    output logic      shift,
    output logic      run,
    output logic      line,
    output logic      done
);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    tx_state_e st_q, st_d;
    logic [IDX_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // data bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (st_q != ST_DATA) begin
            idx_q <= '0;
        end else if (tick) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (wr_req) st_d = ST_START;
            ST_START: if (tick) st_d = ST_DATA;
            ST_DATA:  if (tick && idx_q == IDX_LAST) st_d = ST_STOP;
            ST_STOP:  if (tick) st_d = ST_ACK;
            ST_ACK:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        shift  = 1'b0;
        run    = 1'b0;
        line   = 1'b1;
        done   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                accept = wr_req;
            end
            ST_START: begin
                run  = 1'b1;
                line = 1'b0;
            end
            ST_DATA: begin
                run   = 1'b1;
                line  = data_lsb;
                shift = tick;
            end
            ST_STOP: begin
                run = 1'b1;
            end
            ST_ACK: begin
                done = 1'b1;
            end
            default: begin
                line = 1'b1;
            end
        endcase
    end

    assign st = st_q;

endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
    import dbg_uart_pkg::*;
#(
    parameter int CLK_DIV   = 868,
    parameter int DATA_BITS = 8,
    parameter int BUS_W     = 32,
    parameter bit HOLD_ACK  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic [BUS_W/8-1:0] bus_wstrb,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic               bus_ready,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               tx_out,
    output logic               tx_done
);
    tx_state_e st_q;
    logic      wr_req, rd_req;
    logic      accept, shift, run, bit_tick, data_lsb, done;
    logic      rd_ack_q, wr_ack;
    logic      unused_hi;

    assign wr_req    = bus_valid && (|bus_wstrb);
    assign rd_req    = bus_valid && !(|bus_wstrb);
    assign unused_hi = ^bus_wdata[BUS_W-1:DATA_BITS];

    dbg_uart_baud #(.CLK_DIV(CLK_DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (bit_tick)
    );

    dbg_uart_shreg #(.DATA_BITS(DATA_BITS)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (shift),
        .din   (bus_wdata[DATA_BITS-1:0]),
        .lsb   (data_lsb)
    );

    dbg_uart_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .tick     (bit_tick),
        .data_lsb (data_lsb),
        .st       (st_q),
        .accept   (accept),
        .shift    (shift),
        .run      (run),
        .line     (tx_out),
        .done     (done)
    );

    // read acknowledge: one cycle, independent of the character in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ack_q <= 1'b0;
        end else begin
            rd_ack_q <= rd_req && !rd_ack_q;
        end
    end

    generate
        if (HOLD_ACK) begin : g_hold
            assign wr_ack = done;
        end else begin : g_posted
            logic wr_ack_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wr_ack_q <= 1'b0;
                end else begin
                    wr_ack_q <= accept;
                end
            end
            assign wr_ack = wr_ack_q;
        end
    endgenerate

    assign bus_ready = wr_ack || rd_ack_q;
    assign bus_rdata = '0;
    assign tx_done   = done;

endmodule

// File: rtl/dbg_uart_tx_chk.sv
module dbg_uart_tx_chk
    import dbg_uart_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter bit HOLD_ACK = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic [BUS_W/8-1:0] bus_wstrb,
    input logic               bus_ready,
    input logic               tx_out,
    input logic               tx_done,
    input tx_state_e          st_q,
    input logic               bit_tick
);
    // R2: an accepted write drives the start bit next cycle
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && bus_valid && (|bus_wstrb)) |=> !tx_out)
        else $error("p_start_low_r2");

    // R3: the line does not move inside a bit period
    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && st_q != ST_ACK && !bit_tick) |=> $stable(tx_out))
        else $error("p_bit_hold_r3");

    // R4: line high outside a character
    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_ACK) |-> tx_out)
        else $error("p_idle_high_r4");

    // R5: in stalling mode the end of a character acknowledges the write
    p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD_ACK && tx_done) |-> bus_ready)
        else $error("p_done_ready_r5");

    // R6: one-shot completion pulse
    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done)
        else $error("p_done_once_r6");

    // R7: posted mode acknowledges at acceptance
    p_post_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!HOLD_ACK && st_q == ST_IDLE && bus_valid && (|bus_wstrb)) |=> bus_ready)
        else $error("p_post_ack_r7");

    // R8: a read is acknowledged in the following cycle
    p_read_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !(|bus_wstrb) && !bus_ready) |=> bus_ready)
        else $error("p_read_ack_r8");

endmodule

bind dbg_uart_tx dbg_uart_tx_chk #(.BUS_W(BUS_W), .HOLD_ACK(HOLD_ACK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_wstrb (bus_wstrb),
    .bus_ready (bus_ready),
    .tx_out    (tx_out),
    .tx_done   (tx_done),
    .st_q      (st_q),
    .bit_tick  (bit_tick)
);

// File: tb/dbg_uart_tx_tb_top.sv
`timescale 1ns/1ps
module dbg_uart_tx_tb_top;
    localparam int DIV   = 4;
    localparam int NB    = 8;
    localparam int FRAME = (NB + 2) * DIV;
    localparam int NVEC  = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0000_00A5, 32'hDEAD_BE5A, 32'h0000_00FF,
        32'hFFFF_FF00, 32'h1234_5601, 32'h0000_0080
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // stalling copy
    logic        h_valid = 1'b0;
    logic [3:0]  h_wstrb = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready, h_tx, h_done;
    logic [31:0] h_rdata;

    // posted copy
    logic        p_valid = 1'b0;
    logic [3:0]  p_wstrb = '0;
    logic [31:0] p_wdata = '0;
    logic        p_ready, p_tx, p_done;
    logic [31:0] p_rdata;

    dbg_uart_tx #(.CLK_DIV(DIV), .DATA_BITS(NB), .BUS_W(32), .HOLD_ACK(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(h_valid), .bus_wstrb(h_wstrb),
        .bus_wdata(h_wdata), .bus_ready(h_ready), .bus_rdata(h_rdata),
        .tx_out(h_tx), .tx_done(h_done)
    );

    dbg_uart_tx #(.CLK_DIV(DIV), .DATA_BITS(NB), .BUS_W(32), .HOLD_ACK(1'b0)) dut_p (
        .clk(clk), .rst_n(rst_n), .bus_valid(p_valid), .bus_wstrb(p_wstrb),
        .bus_wdata(p_wdata), .bus_ready(p_ready), .bus_rdata(p_rdata),
        .tx_out(p_tx), .tx_done(p_done)
    );

    task automatic check_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected line level for bit slot b of a character (0 start, NB+1 stop)
    function automatic logic slot_bit(input logic [NB-1:0] d, input int b);
        if (b == 0) return 1'b0;
        if (b <= NB) return d[b-1];
        return 1'b1;
    endfunction

    function automatic string slot_tag(input int b);
        if (b == 0) return "R2 start bit";
        if (b <= NB) return "R3 data bit";
        return "R4 stop bit";
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_hold(input logic [31:0] w);
        bit early = 1'b0;
        @(negedge clk);
        h_valid = 1'b1; h_wstrb = 4'hF; h_wdata = w;
        for (int k = 0; k <= FRAME; k++) begin
            cyc();
            if (k < FRAME) begin
                if (h_ready || h_done) early = 1'b1;
                if (k % DIV == DIV / 2)
                    check_eq(slot_tag(k / DIV), h_tx, slot_bit(w[NB-1:0], k / DIV));
            end else begin
                check_eq("R5 ready at end", h_ready, 1);
                check_eq("R6 done at end", h_done, 1);
                check_eq("R4 line high in ack", h_tx, 1);
                h_valid = 1'b0; h_wstrb = '0; h_wdata = '0;
            end
        end
        check_eq("R5 ready low during frame", early, 0);
        cyc();
        check_eq("R5 ready one cycle", h_ready, 0);
        check_eq("R6 done one cycle", h_done, 0);
        check_eq("R4 idle high", h_tx, 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 tx in reset", h_tx, 1);
        check_eq("R1 ready in reset", h_ready, 0);
        check_eq("R1 done in reset", h_done, 0);
        rst_n = 1'b1;
        repeat (2) cyc();
        check_eq("R1 tx after reset", h_tx, 1);
        check_eq("R1 ready after reset", h_ready, 0);
        check_eq("R1 posted tx after reset", p_tx, 1);
        check_eq("R1 posted done after reset", p_done, 0);

        // R2 R3 R4 R5 R6: table of characters in stalling mode
        for (int v = 0; v < NVEC; v++) send_hold(VEC[v]);

        // R8: read while idle
        begin
            bit moved = 1'b0;
            h_valid = 1'b1; h_wstrb = 4'h0; h_wdata = 32'hFFFF_FFFF;
            cyc();
            check_eq("R8 read ack", h_ready, 1);
            check_eq("R8 read data zero", h_rdata, 0);
            h_valid = 1'b0;
            for (int k = 0; k < 3 * DIV; k++) begin
                cyc();
                if (!h_tx || h_ready || h_done) moved = 1'b1;
            end
            check_eq("R8 read starts nothing", moved, 0);
        end

        // R7 R8: posted mode, read inside frame, queued write back to back
        begin
            logic [7:0] d1 = 8'hC3;
            logic [7:0] d2 = 8'h3C;
            bit ready_bad = 1'b0;
            bit done_bad = 1'b0;
            p_valid = 1'b1; p_wstrb = 4'h1; p_wdata = {24'hABCDEF, d1};
            for (int k = 0; k <= 2 * FRAME + 4; k++) begin
                logic exp_rdy, exp_done;
                int j;
                cyc();
                exp_rdy  = (k == 0) || (k == 1) || (k == FRAME + 2);
                exp_done = (k == FRAME) || (k == 2 * FRAME + 2);
                if (p_ready != exp_rdy) begin
                    ready_bad = 1'b1;
                    check_eq("R7 posted ready timing", p_ready, exp_rdy);
                end
                if (p_done != exp_done) begin
                    done_bad = 1'b1;
                    check_eq("R6 posted done timing", p_done, exp_done);
                end
                if (k < FRAME) begin
                    if (k % DIV == DIV / 2)
                        check_eq(slot_tag(k / DIV), p_tx, slot_bit(d1, k / DIV));
                end else if (k < FRAME + 2) begin
                    check_eq("R7 gap high", p_tx, 1);
                end else begin
                    j = k - (FRAME + 2);
                    if (j < FRAME && j % DIV == DIV / 2)
                        check_eq(slot_tag(j / DIV), p_tx, slot_bit(d2, j / DIV));
                    else if (j >= FRAME)
                        check_eq("R4 posted idle high", p_tx, 1);
                end
                if (k == 0) begin
                    check_eq("R7 write acked at accept", p_ready, 1);
                    p_wstrb = 4'h0; p_wdata = 32'h5555_5555;   // read request
                end else if (k == 1) begin
                    check_eq("R8 read ack in frame", p_ready, 1);
                    check_eq("R8 read data zero in frame", p_rdata, 0);
                    p_valid = 1'b0;
                end else if (k == 3 * DIV) begin
                    p_valid = 1'b1; p_wstrb = 4'h1; p_wdata = {24'h0, d2};
                end else if (k == FRAME + 2) begin
                    check_eq("R7 queued write acked", p_ready, 1);
                    p_valid = 1'b0; p_wstrb = '0;
                end
            end
            check_eq("R7 ready sequence", ready_bad, 0);
            check_eq("R6 done sequence", done_bad, 0);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule